// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side command interpreter of a 16-bit word-wide flash-style memory. A host issues write cycles by raising a write strobe with an address and a data word. The decoder follows the two-cycle unlock prefix and the command cycles that come after it. A completed sequence either switches the read view into identification mode or query mode, or launches a program, sector erase, block erase or chip erase operation. A launch is a one-cycle start pulse, together with the latched target address and data.

Each launched operation keeps the decoder busy for a fixed number of clock cycles, set by one parameter per operation kind. A done pulse marks the end. While the decoder is busy every write cycle is dropped, the exit command included. Any cycle that does not fit the expected step returns the decoder to plain read mode. In identification mode a small constant lookup supplies the manufacturer and device codes on the read side. The memory array and the status-bit logic sit outside this block.

The write side is a plain strobe with no back-pressure: the decoder accepts every strobe and has no ready signal. A strobe must stay low for at least one clock between cycles. Control and status pins are plain levels or one-cycle pulses.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, and after a reset applied in the middle of a sequence, the decoder is in read mode. Busy, done, all start pulses, the ID flag, the query flag and rd_hit are 0, and a partial sequence does not carry over the reset.
- R2: Every command begins with two cycles: low data byte AAh at address 5555h, then 55h at address 2AAAh. Only address bits 14..0 and data bits 7..0 are compared in these cycles.
- R3: After the prefix, a third cycle at 5555h decodes its low byte as follows. 90h sets the ID flag and clears the query flag. 98h sets the query flag and clears the ID flag. F0h clears both. A0h arms a program, and the next write cycle at any address pulses start_prog, with op_addr and op_data holding that cycle's address and data.
- R4: A third cycle of 80h at 5555h must be followed by AAh at 5555h and 55h at 2AAAh. The sixth cycle then decodes as follows: 30h at any address pulses start_sect, 50h at any address pulses start_blk, and 10h at 5555h pulses start_chip. op_addr holds the sixth cycle's address.
- R5: A cycle that does not match the expected step, including a stray write in idle, returns the decoder to read mode and clears both mode flags. That cycle does not count as a first cycle, and a later complete sequence is decoded normally.
- R6: A single write whose low byte is F0h, at any address, clears the ID and query flags.
- R7: A launch raises busy on the same clock as the one-cycle start pulse. Busy stays high for exactly PROG_CYC, SECT_CYC, BLK_CYC or CHIP_CYC clocks according to the operation, and one done pulse follows on the clock where busy falls. A launch clears both mode flags, so the decoder is in read mode when done arrives.
- R8: While busy is high, every write cycle is ignored, F0h included: no start pulse, no mode change and no progress through a sequence.
- R9: A write cycle takes the address from the first clock on which the strobe is sampled high and the data from the last such clock. The decoded result shows on the second rising edge after the strobe is first sampled low.
- R10: With the ID flag set and rd_addr bits 19..1 at zero, rd_hit is 1 and rd_word is MFR_CODE when rd_addr[0]=0, or DEV_CODE when rd_addr[0]=1. In every other case rd_hit is 0 and rd_word is 0.
- R11: The ID and query flags are never set together, and entering either mode through an unlocked sequence clears the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_act | input | 1 | Write strobe, high for the length of one write cycle |
| wr_addr | input | 20 | Write cycle address |
| wr_data | input | 16 | Write cycle data |
| rd_addr | input | 20 | Read address for the ID lookup |
| start_prog | output | 1 | One-cycle program launch |
| start_sect | output | 1 | One-cycle sector erase launch |
| start_blk | output | 1 | One-cycle block erase launch |
| start_chip | output | 1 | One-cycle chip erase launch |
| op_addr | output | 20 | Address of the launched operation |
| op_data | output | 16 | Data word of a launched program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| id_mode | output | 1 | Identification read mode active |
| cfi_mode | output | 1 | Query read mode active |
| rd_hit | output | 1 | rd_addr selects an identification word |
| rd_word | output | 16 | Identification word for rd_addr |

## Verification
The state of the sequencer is hidden, and a wrong step only shows up at the ports two edges after the following strobe falls. It appears there as a mode flag that does not change, or a start pulse that is missing or of the wrong kind. For this reason each table vector checks both flags and any launch after every single write cycle. A timer fault shows as a busy window of the wrong length or a missing done pulse, so the width of the window is counted cycle by cycle. A fault in busy gating shows only after done, as a stale mode flag or an extra launch, and the bench checks both.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMP_AW = 15;
  localparam logic [CMP_AW-1:0] ADR_KEY_A = 15'h5555;
  localparam logic [CMP_AW-1:0] ADR_KEY_B = 15'h2AAA;

  localparam logic [7:0] CD_KEY1 = 8'hAA;
  localparam logic [7:0] CD_KEY2 = 8'h55;
  localparam logic [7:0] CD_PGM  = 8'hA0;
  localparam logic [7:0] CD_ERS  = 8'h80;
  localparam logic [7:0] CD_ID   = 8'h90;
  localparam logic [7:0] CD_QRY  = 8'h98;
  localparam logic [7:0] CD_EXIT = 8'hF0;
  localparam logic [7:0] CD_SECT = 8'h30;
  localparam logic [7:0] CD_BLK  = 8'h50;
  localparam logic [7:0] CD_CHIP = 8'h10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_ERS3, ST_ERS4, ST_ERS5, ST_PGM
  } seq_st_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_PROG, OP_SECT, OP_BLK, OP_CHIP
  } op_kind_t;
endpackage

// File: rtl/wr_capture.sv
module wr_capture #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_act,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          cyc_vld,
  output logic [AW-1:0] cyc_addr,
  output logic [DW-1:0] cyc_data
);
  logic act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      cyc_vld  <= 1'b0;
      cyc_addr <= '0;
      cyc_data <= '0;
    end else begin
      act_q   <= wr_act;
      cyc_vld <= act_q & ~wr_act;
      if (wr_act && !act_q) cyc_addr <= wr_addr;
      if (wr_act)           cyc_data <= wr_data;
    end
  end

  // R9: one decoded cycle per strobe
  assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_vld |=> !cyc_vld);
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_vld,
  input  logic [AW-1:0] cyc_addr,
  input  logic [DW-1:0] cyc_data,
  input  logic          busy,
  output op_kind_t      go_kind,
  output logic          id_mode,
  output logic          cfi_mode,
  output logic          start_prog,
  output logic          start_sect,
  output logic          start_blk,
  output logic          start_chip,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data
);
  seq_st_t st, st_nx;
  logic id_nx, cfi_nx;
  logic at_a, at_b;
  logic [7:0] cd;

  assign at_a = (cyc_addr[CMP_AW-1:0] == ADR_KEY_A);
  assign at_b = (cyc_addr[CMP_AW-1:0] == ADR_KEY_B);
  assign cd   = cyc_data[7:0];

  always_comb begin
    st_nx   = st;
    id_nx   = id_mode;
    cfi_nx  = cfi_mode;
    go_kind = OP_NONE;
    if (cyc_vld && !busy) begin
      st_nx  = ST_IDLE;
      id_nx  = 1'b0;
      cfi_nx = 1'b0;
      unique case (st)
        ST_IDLE: if (at_a && cd == CD_KEY1) begin
          st_nx = ST_KEY1; id_nx = id_mode; cfi_nx = cfi_mode;
        end
        ST_KEY1: if (at_b && cd == CD_KEY2) begin
          st_nx = ST_KEY2; id_nx = id_mode; cfi_nx = cfi_mode;
        end
        ST_KEY2: if (at_a) begin
          unique case (cd)
            CD_PGM:  st_nx = ST_PGM;
            CD_ERS:  st_nx = ST_ERS3;
            CD_ID:   id_nx = 1'b1;
            CD_QRY:  cfi_nx = 1'b1;
            CD_EXIT: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
          endcase
        end
        ST_ERS3: if (at_a && cd == CD_KEY1) st_nx = ST_ERS4;
        ST_ERS4: if (at_b && cd == CD_KEY2) st_nx = ST_ERS5;
        ST_ERS5: begin
          if (cd == CD_SECT)              go_kind = OP_SECT;
          else if (cd == CD_BLK)          go_kind = OP_BLK;
          else if (cd == CD_CHIP && at_a) go_kind = OP_CHIP;
        end
        ST_PGM:  go_kind = OP_PROG;
        default: st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      id_mode    <= 1'b0;
      cfi_mode   <= 1'b0;
      start_prog <= 1'b0;
      start_sect <= 1'b0;
      start_blk  <= 1'b0;
      start_chip <= 1'b0;
      op_addr    <= '0;
      op_data    <= '0;
    end else begin
      st         <= st_nx;
      id_mode    <= id_nx;
      cfi_mode   <= cfi_nx;
      start_prog <= (go_kind == OP_PROG);
      start_sect <= (go_kind == OP_SECT);
      start_blk  <= (go_kind == OP_BLK);
      start_chip <= (go_kind == OP_CHIP);
      if (go_kind != OP_NONE) begin
        op_addr <= cyc_addr;
        op_data <= cyc_data;
      end
    end
  end

  // R8: a cycle arriving while busy leaves sequence, modes and launches untouched
  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc_vld) |=> ($stable(st) && $stable(id_mode) && $stable(cfi_mode) &&
                          !start_prog && !start_sect && !start_blk && !start_chip));

  // R3: a mode flag only rises on a decoded write cycle
  assert_id_needs_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(cyc_vld));

  // R7: a launch leaves the decoder in read mode
  assert_launch_clears_modes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_sect || start_blk || start_chip) |-> (!id_mode && !cfi_mode));
endmodule

// File: rtl/op_timer.sv
module op_timer
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYC = 12,
  parameter int SECT_CYC = 32,
  parameter int BLK_CYC  = 48,
  parameter int CHIP_CYC = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  op_kind_t go_kind,
  output logic     busy,
  output logic     done
);
  localparam int MAX_PS  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_BC  = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int MAX_CYC = (MAX_PS > MAX_BC) ? MAX_PS : MAX_BC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;

  always_comb begin
    unique case (go_kind)
      OP_PROG: load_val = CW'(PROG_CYC - 1);
      OP_SECT: load_val = CW'(SECT_CYC - 1);
      OP_BLK:  load_val = CW'(BLK_CYC - 1);
      OP_CHIP: load_val = CW'(CHIP_CYC - 1);
      default: load_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else if (go_kind != OP_NONE) begin
      busy <= 1'b1;
      done <= 1'b0;
      cnt  <= load_val;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt  <= cnt - CW'(1);
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  // R7: busy ends exactly where done pulses
  assert_done_at_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/id_lookup.sv
module id_lookup #(
  parameter int          AW       = 20,
  parameter int          DW       = 16,
  parameter logic [15:0] MFR_CODE = 16'h00C3,
  parameter logic [15:0] DEV_CODE = 16'h4A15
) (
  input  logic          id_mode,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_hit,
  output logic [DW-1:0] rd_word
);
  logic [DW-1:0] code_tbl [2];

  generate
    for (genvar g = 0; g < 2; g++) begin : g_code
      assign code_tbl[g] = (g == 0) ? DW'(MFR_CODE) : DW'(DEV_CODE);
    end
  endgenerate

  assign rd_hit  = id_mode && (rd_addr[AW-1:1] == '0);
  assign rd_word = rd_hit ? code_tbl[rd_addr[0]] : '0;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int          AW       = 20,
  parameter int          DW       = 16,
  parameter int          PROG_CYC = 12,
  parameter int          SECT_CYC = 32,
  parameter int          BLK_CYC  = 48,
  parameter int          CHIP_CYC = 64,
  parameter logic [15:0] MFR_CODE = 16'h00C3,
  parameter logic [15:0] DEV_CODE = 16'h4A15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_act,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic          start_prog,
  output logic          start_sect,
  output logic          start_blk,
  output logic          start_chip,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          busy,
  output logic          done,
  output logic          id_mode,
  output logic          cfi_mode,
  output logic          rd_hit,
  output logic [DW-1:0] rd_word
);
  logic          cyc_vld;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_data;
  op_kind_t      go_kind;

  wr_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .wr_addr(wr_addr), .wr_data(wr_data),
    .cyc_vld(cyc_vld), .cyc_addr(cyc_addr), .cyc_data(cyc_data)
  );

  cmd_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .cyc_addr(cyc_addr), .cyc_data(cyc_data),
    .busy(busy), .go_kind(go_kind), .id_mode(id_mode), .cfi_mode(cfi_mode),
    .start_prog(start_prog), .start_sect(start_sect), .start_blk(start_blk),
    .start_chip(start_chip), .op_addr(op_addr), .op_data(op_data)
  );

  op_timer #(.PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .BLK_CYC(BLK_CYC),
             .CHIP_CYC(CHIP_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .go_kind(go_kind), .busy(busy), .done(done)
  );

  id_lookup #(.AW(AW), .DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .id_mode(id_mode), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_word(rd_word)
  );

  // R7: at most one launch at a time, and busy rises with it
  assert_one_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_prog, start_sect, start_blk, start_chip}));
  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_sect || start_blk || start_chip) |-> (busy && !$past(busy)));
  // R11: the two read modes exclude each other
  assert_modes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_mode && cfi_mode));
  // R10: the ID window only answers in ID mode
  assert_hit_needs_id_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> id_mode);
endmodule

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;
  localparam int PROG_CYC = 12;
  localparam int SECT_CYC = 32;
  localparam int BLK_CYC  = 48;
  localparam int CHIP_CYC = 64;
  localparam logic [15:0] MFR = 16'h00C3;
  localparam logic [15:0] DEV = 16'h4A15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_act = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [19:0] rd_addr = '0;
  logic start_prog, start_sect, start_blk, start_chip, busy, done, id_mode, cfi_mode, rd_hit;
  logic [19:0] op_addr;
  logic [15:0] op_data, rd_word;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .BLK_CYC(BLK_CYC),
    .CHIP_CYC(CHIP_CYC), .MFR_CODE(MFR), .DEV_CODE(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .start_prog(start_prog), .start_sect(start_sect),
    .start_blk(start_blk), .start_chip(start_chip), .op_addr(op_addr), .op_data(op_data),
    .busy(busy), .done(done), .id_mode(id_mode), .cfi_mode(cfi_mode),
    .rd_hit(rd_hit), .rd_word(rd_word));

  int n_chk = 0, n_bad = 0;
  int n_start = 0, n_done = 0, n_busy = 0;
  int last_kind = 0;
  logic [19:0] last_addr = '0;
  logic [15:0] last_data = '0;

  always @(posedge clk) begin
    if (start_prog) begin n_start <= n_start + 1; last_kind <= 1; end
    if (start_sect) begin n_start <= n_start + 1; last_kind <= 2; end
    if (start_blk)  begin n_start <= n_start + 1; last_kind <= 3; end
    if (start_chip) begin n_start <= n_start + 1; last_kind <= 4; end
    if (start_prog || start_sect || start_blk || start_chip) begin
      last_addr <= op_addr; last_data <= op_data;
    end
    if (done) n_done <= n_done + 1;
  end
  always @(negedge clk) if (busy) n_busy <= n_busy + 1;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [19:0] a, logic [15:0] d);
    @(negedge clk); wr_act = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); @(negedge clk); wr_act = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 500 && busy; k++) @(negedge clk);
  endtask

  task automatic unlock();
    wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055);
  endtask

  // vector: addr[44:25] data[24:9] id[8] cfi[7] kind[6:4] req[3:0]
  function automatic logic [44:0] vv(logic [19:0] a, logic [15:0] d, logic i, logic c,
                                     logic [2:0] k, logic [3:0] r);
    return {a, d, i, c, k, r};
  endfunction

  localparam int NV = 57;
  localparam logic [44:0] TBL [NV] = '{
    vv(20'h05555,16'h00AA,0,0,0,2), vv(20'h02AAA,16'h0055,0,0,0,2),     // R2 prefix
    vv(20'h05555,16'h0090,1,0,0,3),                                      // R3 ID entry
    vv(20'h01234,16'h00F0,0,0,0,6),                                      // R6 single exit
    vv(20'hD5555,16'hFFAA,0,0,0,2), vv(20'h7AAAA,16'h3355,0,0,0,2),     // R2 upper bits ignored
    vv(20'h05555,16'h0098,0,1,0,3),                                      // R3 query entry
    vv(20'h05555,16'h00AA,0,1,0,11), vv(20'h02AAA,16'h0055,0,1,0,11),
    vv(20'h05555,16'h0090,1,0,0,11),                                     // R11 swap modes
    vv(20'h05555,16'h00AA,1,0,0,3), vv(20'h02AAA,16'h0055,1,0,0,3),
    vv(20'h05555,16'h00F0,0,0,0,3),                                      // R3 three-cycle exit
    vv(20'h05555,16'h00AA,0,0,0,3), vv(20'h02AAA,16'h0055,0,0,0,3),
    vv(20'h05555,16'h00A0,0,0,0,3), vv(20'hABCDE,16'hBEEF,0,0,1,3),     // R3 program
    vv(20'h05555,16'h00AA,0,0,0,4), vv(20'h02AAA,16'h0055,0,0,0,4),
    vv(20'h05555,16'h0080,0,0,0,4), vv(20'h05555,16'h00AA,0,0,0,4),
    vv(20'h02AAA,16'h0055,0,0,0,4), vv(20'h7F800,16'h0030,0,0,2,4),     // R4 sector
    vv(20'h05555,16'h00AA,0,0,0,4), vv(20'h02AAA,16'h0055,0,0,0,4),
    vv(20'h05555,16'h0080,0,0,0,4), vv(20'h05555,16'h00AA,0,0,0,4),
    vv(20'h02AAA,16'h0055,0,0,0,4), vv(20'hF8000,16'h0050,0,0,3,4),     // R4 block
    vv(20'h05555,16'h00AA,0,0,0,4), vv(20'h02AAA,16'h0055,0,0,0,4),
    vv(20'h05555,16'h0080,0,0,0,4), vv(20'h05555,16'h00AA,0,0,0,4),
    vv(20'h02AAA,16'h0055,0,0,0,4), vv(20'h05555,16'h0010,0,0,4,4),     // R4 chip
    vv(20'h05555,16'h00AA,0,0,0,5), vv(20'h02AAA,16'h0056,0,0,0,5),     // R5 wrong data
    vv(20'h02AAA,16'h0055,0,0,0,5),
    vv(20'h05555,16'h00AA,0,0,0,5), vv(20'h02AAA,16'h0055,0,0,0,5),
    vv(20'h05555,16'h0090,1,0,0,5),
    vv(20'h05555,16'h00AA,1,0,0,5), vv(20'h02AAB,16'h0055,0,0,0,5),     // R5 wrong address
    vv(20'h05555,16'h00AA,0,0,0,5), vv(20'h02AAA,16'h0055,0,0,0,5),
    vv(20'h05555,16'h0080,0,0,0,5), vv(20'h05555,16'h00AA,0,0,0,5),
    vv(20'h02AAA,16'h0055,0,0,0,5), vv(20'h01234,16'h0010,0,0,0,5),     // R5 chip off-address
    vv(20'h05555,16'h00AA,0,0,0,5), vv(20'h02AAA,16'h0055,0,0,0,5),
    vv(20'h05555,16'h0098,0,1,0,5), vv(20'h00000,16'h0000,0,0,0,5),     // R5 stray write
    vv(20'h05555,16'h00AA,0,0,0,5), vv(20'h02AAA,16'h0055,0,0,0,5),
    vv(20'h05555,16'h0080,0,0,0,5), vv(20'h05555,16'h0055,0,0,0,5)      // R5 erase step 4
  };

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int s0, d0, b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0); chk("R1", "id", id_mode, 0); chk("R1", "cfi", cfi_mode, 0);
    chk("R1", "starts", {start_prog, start_sect, start_blk, start_chip}, 0);
    chk("R1", "done", done, 0); chk("R1", "rd_hit", rd_hit, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      string rq;
      v = TBL[i];
      rq = $sformatf("R%0d vec%0d", v[3:0], i);
      s0 = n_start;
      wr(v[44:25], v[24:9]);
      wait_idle();
      chk(rq, "id", id_mode, v[8]);
      chk(rq, "cfi", cfi_mode, v[7]);
      chk(rq, "launches", n_start - s0, (v[6:4] != 0) ? 1 : 0);
      if (v[6:4] != 0) begin
        chk(rq, "kind", last_kind, v[6:4]);
        chk(rq, "op_addr", last_addr, v[44:25]);
        if (v[6:4] == 1) chk(rq, "op_data", last_data, v[24:9]);
      end
    end

    // R10 ID lookup
    unlock(); wr(20'h05555, 16'h0090);
    rd_addr = 20'h00000; #1;
    chk("R10", "hit a0", rd_hit, 1); chk("R10", "mfr", rd_word, MFR);
    rd_addr = 20'h00001; #1;
    chk("R10", "hit a1", rd_hit, 1); chk("R10", "dev", rd_word, DEV);
    rd_addr = 20'h00002; #1;
    chk("R10", "hit a2", rd_hit, 0); chk("R10", "word a2", rd_word, 0);
    rd_addr = 20'h80001; #1;
    chk("R10", "hit high", rd_hit, 0);
    wr(20'h0ABCD, 16'h00F0);
    rd_addr = 20'h00000; #1;
    chk("R10", "hit after exit", rd_hit, 0); chk("R10", "word after exit", rd_word, 0);

    // R9 address from first strobe clock, data from last, result two edges after low
    unlock();
    @(negedge clk); wr_act = 1'b1; wr_addr = 20'h05555; wr_data = 16'h0000;
    @(negedge clk); wr_addr = 20'h00000; wr_data = 16'h0090;
    @(negedge clk); wr_act = 1'b0;
    @(negedge clk); chk("R9", "id one edge after low", id_mode, 0);
    @(negedge clk); chk("R9", "id two edges after low", id_mode, 1);
    wr(20'h00000, 16'h00F0);
    unlock();
    @(negedge clk); wr_act = 1'b1; wr_addr = 20'h05555; wr_data = 16'h0090;
    @(negedge clk); wr_data = 16'h0000;
    @(negedge clk); wr_act = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "early data dropped", id_mode, 0);

    // R7 program busy window from ID mode, then read mode
    unlock(); wr(20'h05555, 16'h0090);
    unlock(); wr(20'h05555, 16'h00A0);
    s0 = n_start; d0 = n_done; b0 = n_busy;
    wr(20'h00010, 16'h1357);
    wait_idle(); @(negedge clk);
    chk("R7", "prog busy cycles", n_busy - b0, PROG_CYC);
    chk("R7", "done pulses", n_done - d0, 1);
    chk("R7", "launches", n_start - s0, 1);
    chk("R7", "id after done", id_mode, 0);

    // R8 writes during chip erase are ignored
    unlock(); wr(20'h05555, 16'h0080); unlock();
    s0 = n_start; d0 = n_done; b0 = n_busy;
    wr(20'h05555, 16'h0010);
    unlock(); wr(20'h05555, 16'h0090);
    wr(20'h00000, 16'h00F0);
    unlock(); wr(20'h05555, 16'h00A0); wr(20'h00100, 16'h2222);
    chk("R8", "still busy", busy, 1);
    chk("R8", "id during busy", id_mode, 0);
    wait_idle(); @(negedge clk);
    chk("R8", "launches", n_start - s0, 1);
    chk("R8", "kind", last_kind, 4);
    chk("R8", "id after done", id_mode, 0);
    chk("R7", "chip busy cycles", n_busy - b0, CHIP_CYC);
    chk("R7", "chip done", n_done - d0, 1);
    s0 = n_start;
    wr(20'h00200, 16'h3333);
    chk("R8", "no pending program", n_start - s0, 0);

    // R1 reset mid-sequence
    unlock();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    wr(20'h05555, 16'h0090);
    chk("R1", "no carry over reset", id_mode, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule